// File: doc/BRIEF.md
# Victim Exchange Shift Buffer

This block sits on the data path between a 128-bit cache data bus and a 128-bit system data bus. Every bit lane is a four-stage shift register, so the whole array holds one 512-bit cache block as four 128-bit words. When a miss has to evict a dirty block, the block's four words are shifted in from the cache side. The four fill words then arrive from the system bus and go straight through to the cache while the evicted block stays parked. Once the fill is complete, the parked words are shifted out to the bus one word per strobe, in the order they came in. Write-back and fill therefore appear on the bus in reverse order, and the processor never waits for the write-back.

A bypass control reduces each lane to its first stage. An ordinary block write then goes from cache to bus with one register of delay and never uses the victim storage.

The controller is an FSM with five states. ST_EMPTY is idle with no victim. ST_LOAD means one to three victim words are captured. ST_HOLD means all four are captured and the fill is awaited. ST_READY means the fill is complete and the victim may drain. ST_DRAIN means one to three words are left to drain. The transitions are:

- load: ST_EMPTY to ST_LOAD, and ST_LOAD to itself, on a victim load strobe with bypass low.
- loaded: ST_LOAD to ST_HOLD on the fourth load.
- filled: ST_HOLD to ST_READY on the fourth fill beat.
- drain: ST_READY to ST_DRAIN, and ST_DRAIN to itself, on a drain strobe.
- drained: to ST_EMPTY on the last drain.

Top module: `victim_xchg_buf`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, and both `bus_tx_valid` and `cache_wr_valid` are 0.
- R2: While the buffer is empty or partly loaded, each cycle with `vic_load`=1 and `bypass`=0 captures `cache_rd_data` as one victim word. `full` goes to 1 and `empty` to 0 in the cycle after the fourth capture.
- R3: While `full` is 1, `vic_load` strobes are ignored, and the words drained afterwards are the original four.
- R4: Every cycle with `bus_rx_valid`=1 produces `cache_wr_valid`=1 in the next cycle, with `cache_wr_data` equal to that cycle's `bus_rx_data`. This holds in every state.
- R5: Fill beats never alter the stored victim words.
- R6: Drain strobes are ignored until four fill beats have been received after the buffer became full. In that case `bus_tx_valid` stays 0.
- R7: An accepted drain strobe gives `bus_tx_valid`=1 in the next cycle. The victim words come out first in, first out on `bus_tx_data`.
- R8: In the cycle after the fourth drained word, `empty` is 1 and `full` is 0, and a new exchange can start.
- R9: With `bypass`=1 and `vic_load`=1 in the empty state, `cache_rd_data` appears on `bus_tx_data` with `bus_tx_valid`=1 one cycle later. `empty` stays 1 and `full` stays 0.
- R10: A bypass load strobe while a victim is stored is ignored, and the stored words are kept. A drain strobe while empty is also ignored. In both cases `bus_tx_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cache_rd_data | input | 128 | Word read from the cache (victim or write data) |
| vic_load | input | 1 | Beat strobe in the cache-to-bus direction |
| bypass | input | 1 | 1: single-stage pass-through of the strobed word |
| bus_rx_data | input | 128 | Fill word from the system bus |
| bus_rx_valid | input | 1 | Fill beat strobe |
| drain | input | 1 | Request to shift out one victim word |
| cache_wr_data | output | 128 | Fill word toward the cache |
| cache_wr_valid | output | 1 | Fill word valid |
| bus_tx_data | output | 128 | Word toward the system bus |
| bus_tx_valid | output | 1 | Bus word valid |
| full | output | 1 | Four victim words held |
| empty | output | 1 | No victim held |

## Verification
The assertions take for granted that reset is applied before the first strobe and that every strobe input has a known value at each rising edge. They also take `drain` and `vic_load` to be single-cycle requests. An ignored strobe is a legal input, not a protocol breach. The directed stimulus changes inputs only on the falling clock edge. It deliberately offers loads when full, early drains, drains when empty and bypass loads when holding, because the design must tolerate all of these.

// File: rtl/vxb_pkg.sv
package vxb_pkg;
    typedef enum logic [2:0] {
        ST_EMPTY = 3'd0,
        ST_LOAD  = 3'd1,
        ST_HOLD  = 3'd2,
        ST_READY = 3'd3,
        ST_DRAIN = 3'd4
    } vxb_state_e;
endpackage

// File: rtl/vxb_lane_array.sv
module vxb_lane_array #(
    parameter int WORD_W = 128,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              shift_en,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] tap_first,
    output logic [WORD_W-1:0] tap_last
);
    for (genvar b = 0; b < WORD_W; b++) begin : g_lane
        logic [DEPTH-1:0] stg;

        always_ff @(posedge clk) begin
            if (shift_en) begin
                stg <= {stg[DEPTH-2:0], din[b]};
            end
        end

        assign tap_first[b] = stg[0];
        assign tap_last[b]  = stg[DEPTH-1];
    end
endmodule

// File: rtl/vxb_fill_path.sv
module vxb_fill_path #(
    parameter int WORD_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] rx_data,
    input  logic              rx_valid,
    output logic [WORD_W-1:0] wr_data,
    output logic              wr_valid
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
            wr_data  <= '0;
        end else begin
            wr_valid <= rx_valid;
            if (rx_valid) begin
                wr_data <= rx_data;
            end
        end
    end

    // R4: each fill beat reaches the cache side one cycle later, unchanged
    a_r4_fill_passes: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> (wr_valid && wr_data == $past(rx_data)));
endmodule

// File: rtl/vxb_ctrl.sv
module vxb_ctrl
    import vxb_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic bypass_i,
    input  logic drain_i,
    input  logic fill_i,
    output logic shift_o,
    output logic drain_acc_o,
    output logic byp_acc_o,
    output logic full_o,
    output logic empty_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    vxb_state_e       st_q, st_d;
    logic [CNT_W-1:0] vcnt_q, vcnt_d;
    logic [CNT_W-1:0] fcnt_q, fcnt_d;
    logic             load_acc;

    always_comb begin
        load_acc    = load_i && !bypass_i && (st_q == ST_EMPTY || st_q == ST_LOAD);
        byp_acc_o   = load_i && bypass_i && (st_q == ST_EMPTY);
        drain_acc_o = drain_i && (st_q == ST_READY || st_q == ST_DRAIN);
        shift_o     = load_acc || byp_acc_o || drain_acc_o;
    end

    always_comb begin
        st_d   = st_q;
        vcnt_d = vcnt_q;
        fcnt_d = fcnt_q;
        unique case (st_q)
            ST_EMPTY: begin
                fcnt_d = '0;
                if (load_acc) begin
                    vcnt_d = ONE;
                    st_d   = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (load_acc) begin
                    vcnt_d = vcnt_q + ONE;
                    if (vcnt_q == LAST) begin
                        st_d = ST_HOLD;
                    end
                end
            end
            ST_HOLD: begin
                if (fill_i) begin
                    fcnt_d = fcnt_q + ONE;
                    if (fcnt_q == LAST) begin
                        st_d = ST_READY;
                    end
                end
            end
            ST_READY, ST_DRAIN: begin
                if (drain_acc_o) begin
                    vcnt_d = vcnt_q - ONE;
                    st_d   = (vcnt_q == ONE) ? ST_EMPTY : ST_DRAIN;
                end
            end
            default: st_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_EMPTY;
            vcnt_q <= '0;
            fcnt_q <= '0;
        end else begin
            st_q   <= st_d;
            vcnt_q <= vcnt_d;
            fcnt_q <= fcnt_d;
        end
    end

    always_comb begin
        full_o  = (st_q == ST_HOLD) || (st_q == ST_READY);
        empty_o = (st_q == ST_EMPTY);
    end

    // R2: full means exactly DEPTH words are stored
    a_r2_full_count: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> (vcnt_q == CNT_W'(DEPTH)));
    // R3: loads while full do not change the stored word count
    a_r3_full_ignores_load: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && load_i && !drain_i) |=> $stable(vcnt_q));
    // R6: no word leaves while the fill is still outstanding
    a_r6_hold_keeps_victim: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD) |=> $stable(vcnt_q));
    // R8: empty state carries no stored word
    a_r8_empty_count: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o |-> (vcnt_q == '0));
    // R8: flags are never both set
    a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_o && empty_o));
endmodule

// File: rtl/victim_xchg_buf.sv
module victim_xchg_buf #(
    parameter int WORD_W = 128,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] cache_rd_data,
    input  logic              vic_load,
    input  logic              bypass,
    input  logic [WORD_W-1:0] bus_rx_data,
    input  logic              bus_rx_valid,
    input  logic              drain,
    output logic [WORD_W-1:0] cache_wr_data,
    output logic              cache_wr_valid,
    output logic [WORD_W-1:0] bus_tx_data,
    output logic              bus_tx_valid,
    output logic              full,
    output logic              empty
);
    logic              shift_en, drain_acc, byp_acc;
    logic [WORD_W-1:0] tap_first, tap_last;
    logic [WORD_W-1:0] drain_word_q;
    logic              tx_valid_q, sel_first_q;

    vxb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (vic_load),
        .bypass_i    (bypass),
        .drain_i     (drain),
        .fill_i      (bus_rx_valid),
        .shift_o     (shift_en),
        .drain_acc_o (drain_acc),
        .byp_acc_o   (byp_acc),
        .full_o      (full),
        .empty_o     (empty)
    );

    vxb_lane_array #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_lanes (
        .clk       (clk),
        .shift_en  (shift_en),
        .din       (cache_rd_data),
        .tap_first (tap_first),
        .tap_last  (tap_last)
    );

    vxb_fill_path #(.WORD_W(WORD_W)) u_fill (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_data  (bus_rx_data),
        .rx_valid (bus_rx_valid),
        .wr_data  (cache_wr_data),
        .wr_valid (cache_wr_valid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_valid_q   <= 1'b0;
            sel_first_q  <= 1'b0;
            drain_word_q <= '0;
        end else begin
            tx_valid_q  <= drain_acc || byp_acc;
            sel_first_q <= byp_acc;
            if (drain_acc) begin
                drain_word_q <= tap_last;
            end
        end
    end

    assign bus_tx_valid = tx_valid_q;
    assign bus_tx_data  = sel_first_q ? tap_first : drain_word_q;

    // R7: a bus word is only ever the answer to a strobe in the previous cycle
    a_r7_tx_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        bus_tx_valid |-> $past(drain || (vic_load && bypass)));
    // R9: a bypass word leaves the flags untouched
    a_r9_bypass_keeps_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && vic_load && bypass) |=> (empty && bus_tx_valid));
    // R10: drain while empty produces nothing
    a_r10_drain_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !vic_load && drain) |=> !bus_tx_valid);
endmodule

// File: tb/test_victim_xchg_buf.sv
module test_victim_xchg_buf;
    localparam int W = 128;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cache_rd_data = '0;
    logic         vic_load = 1'b0;
    logic         bypass = 1'b0;
    logic [W-1:0] bus_rx_data = '0;
    logic         bus_rx_valid = 1'b0;
    logic         drain = 1'b0;
    logic [W-1:0] cache_wr_data, bus_tx_data;
    logic         cache_wr_valid, bus_tx_valid, full, empty;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    victim_xchg_buf i_victim_xchg_buf (
        .clk(clk), .rst_n(rst_n), .cache_rd_data(cache_rd_data), .vic_load(vic_load),
        .bypass(bypass), .bus_rx_data(bus_rx_data), .bus_rx_valid(bus_rx_valid),
        .drain(drain), .cache_wr_data(cache_wr_data), .cache_wr_valid(cache_wr_valid),
        .bus_tx_data(bus_tx_data), .bus_tx_valid(bus_tx_valid), .full(full), .empty(empty)
    );

    function automatic logic [W-1:0] pat(input int tag, input int k);
        return {4{tag[15:0], k[15:0]}} ^ {W{k[0]}};
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_in();
        vic_load = 1'b0; bypass = 1'b0; drain = 1'b0; bus_rx_valid = 1'b0;
    endtask

    // drive at falling edge, consume at rising edge, sample at next falling edge
    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_load(input logic [W-1:0] d, input logic byp);
        cache_rd_data = d; vic_load = 1'b1; bypass = byp;
        step(); idle_in();
    endtask

    task automatic do_drain();
        drain = 1'b1;
        step(); idle_in();
    endtask

    task automatic do_fill(input logic [W-1:0] d);
        bus_rx_data = d; bus_rx_valid = 1'b1;
        step(); idle_in();
    endtask

    task automatic t_reset();
        step();
        chk("R1 empty", W'(empty), W'(1));
        chk("R1 full", W'(full), W'(0));
        chk("R1 bus_tx_valid", W'(bus_tx_valid), W'(0));
        chk("R1 cache_wr_valid", W'(cache_wr_valid), W'(0));
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_exchange(input int tag, input logic with_junk);
        for (int k = 0; k < 4; k++) begin
            do_load(pat(tag, k), 1'b0);
            if (k < 3) chk("R2 not full mid-load", W'(full), W'(0));
        end
        chk("R2 full after four", W'(full), W'(1));
        chk("R2 not empty", W'(empty), W'(0));
        if (with_junk) begin
            do_load(pat(16'hDEAD, 9), 1'b0);   // R3 ignored load
            chk("R3 load while full", W'(full), W'(1));
            do_load(pat(16'hBEEF, 7), 1'b1);   // R10 bypass while holding
            chk("R10 bypass while holding tx", W'(bus_tx_valid), W'(0));
            do_drain();                        // R6 early drain
            chk("R6 early drain tx", W'(bus_tx_valid), W'(0));
        end
        for (int k = 0; k < 4; k++) begin
            do_fill(pat(tag + 1, k));
            chk("R4 fill valid", W'(cache_wr_valid), W'(1));
            chk("R4 fill data", cache_wr_data, pat(tag + 1, k));
            if (with_junk && k == 1) begin
                drain = 1'b1; step(); idle_in();
                chk("R6 drain mid-fill", W'(bus_tx_valid), W'(0));
            end
        end
        chk("R5 still full after fill", W'(full), W'(1));
        for (int k = 0; k < 4; k++) begin
            do_drain();
            chk("R7 drain valid", W'(bus_tx_valid), W'(1));
            chk("R7 R5 R3 drain order", bus_tx_data, pat(tag, k));
        end
        chk("R8 empty after drain", W'(empty), W'(1));
        chk("R8 not full", W'(full), W'(0));
    endtask

    task automatic t_drain_empty();
        do_drain();
        chk("R10 drain while empty", W'(bus_tx_valid), W'(0));
        chk("R10 still empty", W'(empty), W'(1));
    endtask

    task automatic t_bypass();
        for (int k = 0; k < 3; k++) begin
            do_load(pat(16'h0B0B, k), 1'b1);
            chk("R9 bypass valid", W'(bus_tx_valid), W'(1));
            chk("R9 bypass data", bus_tx_data, pat(16'h0B0B, k));
            chk("R9 stays empty", W'(empty), W'(1));
        end
        step();
        chk("R9 valid single cycle", W'(bus_tx_valid), W'(0));
    endtask

    task automatic t_fill_idle();
        do_fill(pat(16'h7777, 3));
        chk("R4 fill while empty", cache_wr_data, pat(16'h7777, 3));
        chk("R4 fill while empty flags", W'(empty), W'(1));
        step();
        chk("R4 valid drops", W'(cache_wr_valid), W'(0));
    endtask

    initial begin
        idle_in();
        t_reset();
        t_exchange(16'h1100, 1'b0);
        t_drain_empty();
        t_exchange(16'h2200, 1'b1);
        t_bypass();
        t_fill_idle();
        t_exchange(16'h3300, 1'b1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule